// File: doc/BRIEF.md
# Banked Memory Map Controller

This block sits between a 16-bit-address CPU and its memories and decides, for every access, which memory answers and at which physical offset. An 8-bit mapping register, written and read back over an I/O port, sets the layout. Three CPU windows are remapped independently from that one byte. The low 32 KB window can show one of three internal ROM sections, the ROM cartridge, or either half of main RAM. The 16 KB middle window shows one of three 16 KB cells of main RAM, or extra cartridge RAM. The C000-E7FF window shows either main RAM or an 8 KB video RAM overlay; with the overlay on, the 2 KB just above it vanishes. E800-FFFF is always main RAM.

Decoding is purely combinational from the stored register and the current address. The block drives one select line per memory, the physical address, a gated write strobe (never raised for ROM or for a hole), and a steered read byte that reads as all ones wherever nothing is mapped. The memories and the CPU live outside the block.

The decoder works as a set of named modes. The address first falls into one of five regions: LOW (0000-7FFF), MID (8000-BFFF), VIDEO (C000-DFFF), GAP (E000-E7FF) and TOP (E800-FFFF). In LOW the mode is ROM, RAM_LOW, RAM_HIGH or BAD. In MID it is CELL0, CELL1, CELL2 or EXT. The overlay flag picks between main RAM and video RAM for VIDEO, and between main RAM and a hole for GAP. A register write moves the block to its new modes on the clock edge that takes the write. There are no other transitions.

Top module: `mmap_ctrl`

## Requirements
- R1: The mapping register resets to 0x00. After a write with `cfg_we` high, `cfg_rdata` returns the full written byte from the next clock edge on, bit 7 included.
- R2: The ROM mode of LOW is code 0 in bits 3:2. With section 0, 1 or 2 in bits 1:0, an access to 0000-7FFF selects internal ROM (`sel_irom`) at physical address {section, cpu_addr[14:0]}, and `mem_we` stays low.
- R3: In ROM mode with section 3, LOW selects the ROM cartridge (`sel_crom`) at physical address cpu_addr[14:0] when `cart_present` is 1, with `mem_we` low. When `cart_present` is 0 the window is unmapped.
- R4: Code 1 in bits 3:2 (RAM_LOW) maps LOW to main RAM at cpu_addr[14:0]. Code 2 (RAM_HIGH) maps it to main RAM at 0x8000 + cpu_addr[14:0]. In both, `mem_we` follows `cpu_we`.
- R5: Code 3 in bits 3:2 (BAD) leaves 0000-7FFF unmapped.
- R6: Codes 0, 1 and 2 in bits 5:4 (CELL0 to CELL2) map 8000-BFFF to main RAM at code × 0x4000 + cpu_addr[13:0], and the window is writable.
- R7: Code 3 in bits 5:4 (EXT) maps 8000-BFFF to cartridge RAM (`sel_cram`) at cpu_addr[13:0] when `ext_ram_fitted` is 1. When it is 0 the window is unmapped.
- R8: With bit 6 set to 1, C000-DFFF selects video RAM (`sel_vram`) at cpu_addr[12:0], and E000-E7FF is unmapped.
- R9: With bit 6 set to 0, C000-E7FF selects main RAM at physical address equal to cpu_addr.
- R10: E800-FFFF always selects main RAM at physical address equal to cpu_addr, whatever the register holds.
- R11: On an unmapped access, `unmapped` is 1, no select is raised, `phys_addr` is 0, `mem_we` is 0 and `cpu_rdata` is 0xFF. On a mapped access, `cpu_rdata` is the read byte of the selected memory.
- R12: Bit 7 of the register is stored but changes no output of the decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the mapping register |
| cfg_wdata | input | 8 | Byte written into the mapping register |
| cfg_rdata | output | 8 | Current mapping register value |
| cart_present | input | 1 | ROM cartridge is plugged in |
| ext_ram_fitted | input | 1 | Installed RAM is above 64 KB |
| cpu_addr | input | 16 | CPU memory address |
| cpu_we | input | 1 | CPU write request |
| irom_rdata | input | 8 | Read byte from internal ROM |
| mram_rdata | input | 8 | Read byte from main RAM |
| vram_rdata | input | 8 | Read byte from video RAM |
| crom_rdata | input | 8 | Read byte from cartridge ROM |
| cram_rdata | input | 8 | Read byte from cartridge RAM |
| cpu_rdata | output | 8 | Read byte returned to the CPU |
| sel_irom | output | 1 | Internal ROM selected |
| sel_mram | output | 1 | Main RAM selected |
| sel_vram | output | 1 | Video RAM selected |
| sel_crom | output | 1 | Cartridge ROM selected |
| sel_cram | output | 1 | Cartridge RAM selected |
| phys_addr | output | 17 | Physical address inside the selected memory |
| mem_we | output | 1 | Gated write strobe to the selected memory |
| unmapped | output | 1 | No memory answers this address |

## Verification
A vector table covers every code of each window field. Each code is applied at addresses placed at a window's first byte, its last byte, or inside it, so an off-by-one region boundary or a wrong offset bit shows up as a wrong select or a wrong physical address. The ROM-cartridge and cartridge-RAM codes run with their presence inputs both high and low, which separates "mapped to the cartridge" from "hole". Writes are issued to ROM, RAM and holes to tell a working write gate from one that leaks. Bit 7 and unrelated field values are toggled against vectors that are otherwise the same, so any cross-coupling between fields shows up. Directed tests cover the reset value, full-byte readback and a reset mid-run.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

    // Memory targets; index order also fixes the read-mux lane order.
    typedef enum logic [2:0] {
        DEV_NONE = 3'd0,
        DEV_IROM = 3'd1,
        DEV_MRAM = 3'd2,
        DEV_VRAM = 3'd3,
        DEV_CROM = 3'd4,
        DEV_CRAM = 3'd5
    } dev_e;

    localparam int unsigned NUM_DEV = 5;

    // Address regions of the CPU map.
    typedef enum logic [2:0] {
        RGN_LOW   = 3'd0,
        RGN_MID   = 3'd1,
        RGN_VIDEO = 3'd2,
        RGN_GAP   = 3'd3,
        RGN_TOP   = 3'd4
    } region_e;

    // Modes of the low window (register bits 3:2).
    typedef enum logic [1:0] {
        LO_ROM      = 2'd0,
        LO_RAM_LOW  = 2'd1,
        LO_RAM_HIGH = 2'd2,
        LO_BAD      = 2'd3
    } lo_mode_e;

    // Modes of the middle window (register bits 5:4).
    typedef enum logic [1:0] {
        MID_CELL0 = 2'd0,
        MID_CELL1 = 2'd1,
        MID_CELL2 = 2'd2,
        MID_EXT   = 2'd3
    } mid_mode_e;

    // Mapping fields that steer the decode (bit 7 is storage only).
    typedef struct packed {
        logic      vid_on;
        mid_mode_e mid_mode;
        lo_mode_e  lo_mode;
        logic [1:0] rom_sec;
    } map_cfg_t;

    localparam logic [1:0] CART_SECTION = 2'd3;

endpackage

// File: rtl/mmap_cfg_reg.sv
module mmap_cfg_reg #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= wdata;
        end
    end

    // R1: a write is visible on the register output one edge later
    p_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (q == $past(wdata)));

    // R1: without a write the value holds
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && $past(rst_n)) |=> $stable(q));

endmodule

// File: rtl/mmap_window_decode.sv
module mmap_window_decode
    import mmap_pkg::*;
#(
    parameter int unsigned AW   = 16,
    parameter int unsigned PA_W = 17
) (
    input  map_cfg_t          cfg,
    input  logic              cart_present,
    input  logic              ext_ram_fitted,
    input  logic [AW-1:0]     addr,
    output dev_e              dev,
    output logic [PA_W-1:0]   phys
);

    localparam int unsigned ROM_OFS_W = AW - 1;   // 32 KB window
    localparam int unsigned CELL_W    = AW - 2;   // 16 KB cell
    localparam int unsigned VID_W     = AW - 3;   // 8 KB overlay
    localparam logic [AW-1:0] MID_BASE = AW'(1) << (AW - 1);
    localparam logic [AW-1:0] VID_BASE = MID_BASE | (AW'(1) << (AW - 2));
    localparam logic [AW-1:0] GAP_BASE = VID_BASE | (AW'(1) << (AW - 3));
    localparam logic [AW-1:0] TOP_BASE = GAP_BASE | (AW'(1) << (AW - 5));

    region_e rgn;

    always_comb begin
        if (addr < MID_BASE) begin
            rgn = RGN_LOW;
        end else if (addr < VID_BASE) begin
            rgn = RGN_MID;
        end else if (addr < GAP_BASE) begin
            rgn = RGN_VIDEO;
        end else if (addr < TOP_BASE) begin
            rgn = RGN_GAP;
        end else begin
            rgn = RGN_TOP;
        end
    end

    always_comb begin
        dev  = DEV_NONE;
        phys = '0;
        unique case (rgn)
            RGN_LOW: begin
                unique case (cfg.lo_mode)
                    LO_ROM: begin
                        if (cfg.rom_sec != CART_SECTION) begin
                            dev  = DEV_IROM;
                            phys = PA_W'({cfg.rom_sec, addr[ROM_OFS_W-1:0]});
                        end else if (cart_present) begin
                            dev  = DEV_CROM;
                            phys = PA_W'(addr[ROM_OFS_W-1:0]);
                        end
                    end
                    LO_RAM_LOW: begin
                        dev  = DEV_MRAM;
                        phys = PA_W'({1'b0, addr[ROM_OFS_W-1:0]});
                    end
                    LO_RAM_HIGH: begin
                        dev  = DEV_MRAM;
                        phys = PA_W'({1'b1, addr[ROM_OFS_W-1:0]});
                    end
                    LO_BAD: begin
                        dev  = DEV_NONE;
                    end
                endcase
            end
            RGN_MID: begin
                unique case (cfg.mid_mode)
                    MID_CELL0, MID_CELL1, MID_CELL2: begin
                        dev  = DEV_MRAM;
                        phys = PA_W'({cfg.mid_mode, addr[CELL_W-1:0]});
                    end
                    MID_EXT: begin
                        if (ext_ram_fitted) begin
                            dev  = DEV_CRAM;
                            phys = PA_W'(addr[CELL_W-1:0]);
                        end
                    end
                endcase
            end
            RGN_VIDEO: begin
                if (cfg.vid_on) begin
                    dev  = DEV_VRAM;
                    phys = PA_W'(addr[VID_W-1:0]);
                end else begin
                    dev  = DEV_MRAM;
                    phys = PA_W'(addr);
                end
            end
            RGN_GAP: begin
                if (!cfg.vid_on) begin
                    dev  = DEV_MRAM;
                    phys = PA_W'(addr);
                end
            end
            RGN_TOP: begin
                dev  = DEV_MRAM;
                phys = PA_W'(addr);
            end
        endcase
    end

endmodule

// File: rtl/mmap_rdata_mux.sv
module mmap_rdata_mux
    import mmap_pkg::*;
#(
    parameter int unsigned DW   = 8,
    parameter int unsigned NDEV = NUM_DEV
) (
    input  dev_e                      dev,
    input  logic [NDEV-1:0][DW-1:0]   lane_rdata,
    output logic [DW-1:0]             rdata
);

    logic [NDEV-1:0]          hit;
    logic [NDEV-1:0][DW-1:0]  masked;

    // Lane i serves device code i+1.
    for (genvar i = 0; i < NDEV; i++) begin : g_lane
        assign hit[i]    = (dev == dev_e'(3'(i + 1)));
        assign masked[i] = hit[i] ? lane_rdata[i] : '0;
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < NDEV; k++) begin
            rdata = rdata | masked[k];
        end
        if (hit == '0) begin
            rdata = '1;
        end
    end

endmodule

// File: rtl/mmap_ctrl.sv
module mmap_ctrl
    import mmap_pkg::*;
#(
    parameter int unsigned AW   = 16,
    parameter int unsigned DW   = 8,
    parameter int unsigned PA_W = 17
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [7:0]      cfg_wdata,
    output logic [7:0]      cfg_rdata,
    input  logic            cart_present,
    input  logic            ext_ram_fitted,
    input  logic [AW-1:0]   cpu_addr,
    input  logic            cpu_we,
    input  logic [DW-1:0]   irom_rdata,
    input  logic [DW-1:0]   mram_rdata,
    input  logic [DW-1:0]   vram_rdata,
    input  logic [DW-1:0]   crom_rdata,
    input  logic [DW-1:0]   cram_rdata,
    output logic [DW-1:0]   cpu_rdata,
    output logic            sel_irom,
    output logic            sel_mram,
    output logic            sel_vram,
    output logic            sel_crom,
    output logic            sel_cram,
    output logic [PA_W-1:0] phys_addr,
    output logic            mem_we,
    output logic            unmapped
);

    localparam int unsigned CFG_W = 8;

    logic [CFG_W-1:0] cfg_q;
    map_cfg_t         cfg_f;
    dev_e             dev;
    logic             ro_target;
    logic [NUM_DEV-1:0][DW-1:0] lanes;

    mmap_cfg_reg #(.DW(CFG_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .q     (cfg_q)
    );

    assign cfg_rdata = cfg_q;
    assign cfg_f     = map_cfg_t'(cfg_q[6:0]);

    mmap_window_decode #(.AW(AW), .PA_W(PA_W)) u_dec (
        .cfg            (cfg_f),
        .cart_present   (cart_present),
        .ext_ram_fitted (ext_ram_fitted),
        .addr           (cpu_addr),
        .dev            (dev),
        .phys           (phys_addr)
    );

    assign lanes = {cram_rdata, crom_rdata, vram_rdata, mram_rdata, irom_rdata};

    mmap_rdata_mux #(.DW(DW), .NDEV(NUM_DEV)) u_mux (
        .dev        (dev),
        .lane_rdata (lanes),
        .rdata      (cpu_rdata)
    );

    always_comb begin
        sel_irom = 1'b0;
        sel_mram = 1'b0;
        sel_vram = 1'b0;
        sel_crom = 1'b0;
        sel_cram = 1'b0;
        unique case (dev)
            DEV_IROM: sel_irom = 1'b1;
            DEV_MRAM: sel_mram = 1'b1;
            DEV_VRAM: sel_vram = 1'b1;
            DEV_CROM: sel_crom = 1'b1;
            DEV_CRAM: sel_cram = 1'b1;
            default:  ;
        endcase
    end

    assign unmapped  = (dev == DEV_NONE);
    assign ro_target = (dev == DEV_IROM) || (dev == DEV_CROM);
    assign mem_we    = cpu_we && !unmapped && !ro_target;

    // R2 / R3: ROM targets never see a write strobe
    p_rom_nowrite_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_irom || sel_crom) |-> !mem_we);

    // R3: cartridge ROM never selected while absent
    p_cart_absent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cart_present |-> !sel_crom);

    // R5: invalid low-window code leaves a hole
    p_bad_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[3:2] == 2'd3 && !cpu_addr[AW-1]) |-> unmapped);

    // R7: extension RAM needs the size input
    p_ext_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_ram_fitted |-> !sel_cram);

    // R8: overlay hides the 2 KB above it
    p_vram_hole_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[6] && cpu_addr[AW-1:AW-5] == 5'b11100) |-> (unmapped && !mem_we));

    // R10: the top range is fixed main RAM
    p_top_fixed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[AW-1:AW-5] == 5'b11101 || cpu_addr[AW-1:AW-4] == 4'b1111)
            |-> (sel_mram && phys_addr == PA_W'(cpu_addr)));

    // R11: holes read as all ones and select nothing
    p_hole_ones_r11: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> (cpu_rdata == '1 && $countones({sel_irom, sel_mram, sel_vram,
                                                     sel_crom, sel_cram}) == 0));

    // R11: at most one memory is selected
    p_one_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_irom, sel_mram, sel_vram, sel_crom, sel_cram}));

endmodule

// File: tb/sim_mmap_ctrl.sv
`timescale 1ns/1ps
module sim_mmap_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        cart_present = 1'b0;
    logic        ext_ram_fitted = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic        cpu_we = 1'b0;
    logic [7:0]  cpu_rdata;
    logic        sel_irom, sel_mram, sel_vram, sel_crom, sel_cram;
    logic [16:0] phys_addr;
    logic        mem_we, unmapped;

    localparam logic [7:0] D_IROM = 8'h11;
    localparam logic [7:0] D_MRAM = 8'h22;
    localparam logic [7:0] D_VRAM = 8'h33;
    localparam logic [7:0] D_CROM = 8'h44;
    localparam logic [7:0] D_CRAM = 8'h55;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    mmap_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cart_present(cart_present),
        .ext_ram_fitted(ext_ram_fitted), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
        .irom_rdata(D_IROM), .mram_rdata(D_MRAM), .vram_rdata(D_VRAM),
        .crom_rdata(D_CROM), .cram_rdata(D_CRAM), .cpu_rdata(cpu_rdata),
        .sel_irom(sel_irom), .sel_mram(sel_mram), .sel_vram(sel_vram),
        .sel_crom(sel_crom), .sel_cram(sel_cram), .phys_addr(phys_addr),
        .mem_we(mem_we), .unmapped(unmapped)
    );

    // {req[3:0], cfg[7:0], cart, ext, we, addr[15:0], sel[4:0], phys[16:0], mwe}
    // sel order: irom, mram, vram, crom, cram
    localparam int NV = 21;
    localparam logic [53:0] VEC [NV] = '{
        {4'd2,  8'h00, 1'b0, 1'b0, 1'b1, 16'h1234, 5'b10000, 17'h01234, 1'b0}, // R2
        {4'd2,  8'h02, 1'b0, 1'b0, 1'b0, 16'h7FFF, 5'b10000, 17'h17FFF, 1'b0}, // R2
        {4'd3,  8'h03, 1'b1, 1'b0, 1'b1, 16'h0100, 5'b00010, 17'h00100, 1'b0}, // R3
        {4'd3,  8'h03, 1'b0, 1'b0, 1'b1, 16'h0100, 5'b00000, 17'h00000, 1'b0}, // R3
        {4'd4,  8'h04, 1'b0, 1'b0, 1'b1, 16'h4567, 5'b01000, 17'h04567, 1'b1}, // R4
        {4'd4,  8'h08, 1'b0, 1'b0, 1'b1, 16'h0010, 5'b01000, 17'h08010, 1'b1}, // R4
        {4'd5,  8'h0C, 1'b1, 1'b1, 1'b1, 16'h2000, 5'b00000, 17'h00000, 1'b0}, // R5
        {4'd6,  8'h00, 1'b0, 1'b0, 1'b1, 16'h8001, 5'b01000, 17'h00001, 1'b1}, // R6
        {4'd6,  8'h10, 1'b0, 1'b0, 1'b1, 16'h9ABC, 5'b01000, 17'h05ABC, 1'b1}, // R6
        {4'd6,  8'h20, 1'b0, 1'b0, 1'b0, 16'hBFFF, 5'b01000, 17'h0BFFF, 1'b0}, // R6
        {4'd7,  8'h30, 1'b0, 1'b1, 1'b1, 16'hA000, 5'b00001, 17'h02000, 1'b1}, // R7
        {4'd7,  8'h30, 1'b1, 1'b0, 1'b1, 16'hA000, 5'b00000, 17'h00000, 1'b0}, // R7
        {4'd8,  8'h40, 1'b0, 1'b0, 1'b1, 16'hC123, 5'b00100, 17'h00123, 1'b1}, // R8
        {4'd8,  8'h40, 1'b0, 1'b0, 1'b0, 16'hDFFF, 5'b00100, 17'h01FFF, 1'b0}, // R8
        {4'd8,  8'h40, 1'b0, 1'b0, 1'b1, 16'hE400, 5'b00000, 17'h00000, 1'b0}, // R8
        {4'd9,  8'h00, 1'b0, 1'b0, 1'b1, 16'hE7FF, 5'b01000, 17'h0E7FF, 1'b1}, // R9
        {4'd9,  8'h00, 1'b0, 1'b0, 1'b0, 16'hC000, 5'b01000, 17'h0C000, 1'b0}, // R9
        {4'd10, 8'hFF, 1'b0, 1'b0, 1'b1, 16'hE800, 5'b01000, 17'h0E800, 1'b1}, // R10
        {4'd10, 8'h4C, 1'b0, 1'b0, 1'b0, 16'hFFFF, 5'b01000, 17'h0FFFF, 1'b0}, // R10
        {4'd12, 8'h84, 1'b0, 1'b0, 1'b1, 16'h4567, 5'b01000, 17'h04567, 1'b1}, // R12
        {4'd12, 8'hC0, 1'b0, 1'b0, 1'b1, 16'hC123, 5'b00100, 17'h00123, 1'b1}  // R12
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    function automatic logic [7:0] exp_rdata(input logic [4:0] s);
        case (s)
            5'b10000: return D_IROM;
            5'b01000: return D_MRAM;
            5'b00100: return D_VRAM;
            5'b00010: return D_CROM;
            5'b00001: return D_CRAM;
            default:  return 8'hFF;
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset value and the default layout (ROM section 0 low)
        check("R1", "reset value", 32'(cfg_rdata), 32'h00);
        cpu_addr = 16'h0042;
        #1;
        check("R1", "reset low window sel", 32'({sel_irom, sel_mram, sel_vram, sel_crom, sel_cram}),
              32'b10000);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            logic [53:0] v;
            string rq;
            v = VEC[i];
            rq = $sformatf("R%0d", v[53:50]);
            write_cfg(v[49:42]);
            cart_present   = v[41];
            ext_ram_fitted = v[40];
            cpu_we         = v[39];
            cpu_addr       = v[38:23];
            #1;
            check(rq, "sel", 32'({sel_irom, sel_mram, sel_vram, sel_crom, sel_cram}), 32'(v[22:18]));
            check(rq, "phys", 32'(phys_addr), 32'(v[17:1]));
            check(rq, "mem_we", 32'(mem_we), 32'(v[0]));
            check("R11", "cpu_rdata", 32'(cpu_rdata), 32'(exp_rdata(v[22:18])));
            check("R11", "unmapped", 32'(unmapped), 32'(v[22:18] == 5'b0));
            check("R1", "readback", 32'(cfg_rdata), 32'(v[49:42]));
        end

        // R1: full-byte readback including bit 7
        write_cfg(8'hA5);
        check("R1", "readback A5", 32'(cfg_rdata), 32'hA5);

        // R1: no write strobe leaves the value untouched
        @(negedge clk);
        cfg_wdata = 8'h3C;
        @(negedge clk);
        check("R1", "hold without strobe", 32'(cfg_rdata), 32'hA5);

        // R12: bit 7 toggled alone gives identical decode (low window RAM_HIGH)
        write_cfg(8'h08);
        cpu_addr = 16'h1000; cpu_we = 1'b1; #1;
        check("R12", "phys bit7 clear", 32'(phys_addr), 32'h09000);
        write_cfg(8'h88);
        #1;
        check("R12", "phys bit7 set", 32'(phys_addr), 32'h09000);
        check("R12", "mem_we bit7 set", 32'(mem_we), 32'h1);

        // R4: middle field change does not disturb the low window
        write_cfg(8'h34);
        cpu_addr = 16'h7FFF; #1;
        check("R4", "low window with mid=3", 32'(phys_addr), 32'h07FFF);

        // R1: reset mid-run returns to 0x00
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        cpu_addr = 16'h0042; cpu_we = 1'b1; #1;
        check("R1", "reset mid-run", 32'(cfg_rdata), 32'h00);
        check("R2", "ROM after reset blocks write", 32'(mem_we), 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule